// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and the write engine of a simple NOR-style flash model. It takes command writes from the host over a select, an active-low write strobe, an address and an 8-bit data bus. It decodes them into a read mode, either array or status. It runs the two-write arm/confirm sequences that guard every erase, program and lock-bit change. Each confirmed operation goes to a stub write engine that stays busy for a fixed number of cycles per operation kind.

The controller keeps a status register with a ready flag and sticky error flags, and drives an active-low busy output. Two digital flags guard it. A program-enable flag refuses operations at confirm time. A supply-lockout flag drops the interface to array reads and ignores writes while it is set. A separate active-low device-reset input aborts any running operation and clears the status errors. It then holds the device in a timed reset sequence: a minimum low time, then a fixed release delay. Busy stays low across that whole sequence when an operation was cut short.

Top module: `fci_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the read mode is array (`rd_stat`=0), `stat` reads 0x80, `busy_n` is 1 and `op_go` is 0.
- R2: A command is taken once, on the first clock edge where `sel`=1 and `wr_n`=0. A strobe held for several cycles counts as one write, even if `din` changes while it is held. With `sel`=0 or `wr_n`=1 no write is taken.
- R3: Idle command codes: 0xFF selects array reads, 0x70 selects status reads, 0x50 clears the four error flags and leaves the mode alone. Any code outside the command set leaves mode, status and engine unchanged.
- R4: 0x20 followed by 0xD0 starts an erase (`op_kind`=0). 0x60 followed by 0x01 starts a lock-bit set (`op_kind`=2). 0x60 followed by 0xD0 starts a lock-bit clear (`op_kind`=3). `op_addr` carries the address of the confirm write. `op_go` pulses for one cycle after the confirm edge. Arming and confirming both select status reads.
- R5: 0x40 followed by any byte starts a program (`op_kind`=1), with that byte on `op_data` and its address on `op_addr`.
- R6: An armed erase or lock sequence confirmed with any other byte starts nothing. It sets the sequence-error flag `stat[2]` and selects status reads.
- R7: With `pen_ok`=0 at the confirm write, no operation starts. `stat[3]` is set, together with `stat[5]` for erase or lock clear, or `stat[4]` for program or lock set.
- R8: `busy_n` goes low on the confirm edge and stays low for ERASE_CYC, PROG_CYC or LOCK_CYC cycles, and `stat[7]` follows it. Every command write made while busy is ignored.
- R9: The read mode does not change when an operation ends, nor on `sel` or `pen_ok` changes without a write.
- R10: The error flags `stat[5:2]` stay set until a 0x50 write or a device reset.
- R11: The clock edge that sees `vdd_low`=1 selects array reads and drops any armed sequence. Writes are ignored while it stays 1.
- R12: While the device reset sequence runs, writes are ignored, and the first edge that sees `dev_off_n`=0 clears `stat[5:2]`. The device returns to normal operation RST_REL cycles after it enters the release phase. It enters that phase on the first edge seeing `dev_off_n`=1, but no earlier than RST_HOLD edges after entry.
- R13: A device reset during an operation aborts it for good. `busy_n` stays low until the reset sequence ends, then goes high with array reads selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Device select, active high |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | AW | Write address |
| din | input | 8 | Command or program data |
| pen_ok | input | 1 | Program-enable level valid |
| vdd_low | input | 1 | Supply below lockout |
| dev_off_n | input | 1 | Device reset / power-down, active low |
| rd_stat | output | 1 | 1 = status reads selected, 0 = array reads |
| stat | output | 8 | Status register |
| busy_n | output | 1 | Low while busy or while an abort is pending |
| op_go | output | 1 | One-cycle pulse for a started operation |
| op_kind | output | 2 | Kind of the started operation |
| op_addr | output | AW | Address of the started operation |
| op_data | output | 8 | Data of the started operation |

## Verification
The bound checker watches, on every cycle, the invariants that hold on any trace. An operation starts only after an enabled, unlocked write with program enable valid and the engine idle. Supply lockout forces array reads. The mode holds without a write. Error flags only fall on a clear write or a device reset. Busy stays low through an aborted operation, and the ready flag mirrors busy. The exact work is left to the directed scenarios: which codes decode to which operation, the per-kind busy lengths, the release point of the reset sequence for long and short pulses, and the proof that an aborted operation never resumes.

// File: rtl/fci_pkg.sv
package fci_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_ARRAY  = 8'hFF;
    localparam logic [CMD_W-1:0] CMD_STATUS = 8'h70;
    localparam logic [CMD_W-1:0] CMD_CLR    = 8'h50;
    localparam logic [CMD_W-1:0] CMD_ERASE  = 8'h20;
    localparam logic [CMD_W-1:0] CMD_PROG   = 8'h40;
    localparam logic [CMD_W-1:0] CMD_LOCK   = 8'h60;
    localparam logic [CMD_W-1:0] CMD_GO     = 8'hD0;
    localparam logic [CMD_W-1:0] CMD_LSET   = 8'h01;

    typedef enum logic {
        RD_ARRAY  = 1'b0,
        RD_STATUS = 1'b1
    } rd_mode_e;

    typedef enum logic [1:0] {
        ARM_NONE  = 2'd0,
        ARM_ERASE = 2'd1,
        ARM_PROG  = 2'd2,
        ARM_LOCK  = 2'd3
    } arm_e;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_LSET  = 2'd2,
        OP_LCLR  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_HOLD = 2'd1,
        PH_REL  = 2'd2
    } phase_e;

    typedef struct packed {
        logic ers;
        logic prg;
        logic pen;
        logic seq;
    } err_t;

    // status layout: ready at 7, error flags at 5..2
    function automatic logic [CMD_W-1:0] pack_status(input logic ready, input err_t e);
        return {ready, 1'b0, e.ers, e.prg, e.pen, e.seq, 2'b00};
    endfunction

    function automatic logic charges_erase_flag(input op_e k);
        return (k == OP_ERASE) || (k == OP_LCLR);
    endfunction

endpackage

// File: rtl/fci_busif.sv
module fci_busif
    import fci_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    input  logic [CMD_W-1:0] din,
    output logic             wr_evt,
    output logic [AW-1:0]    evt_addr,
    output logic [CMD_W-1:0] evt_data
);
    logic strobe;
    logic strobe_q;

    assign strobe = sel & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    // one event per strobe, on its leading edge
    assign wr_evt   = strobe & ~strobe_q;
    assign evt_addr = addr;
    assign evt_data = din;
endmodule

// File: rtl/fci_rstseq.sv
module fci_rstseq
    import fci_pkg::*;
#(
    parameter int RST_HOLD = 6,
    parameter int RST_REL  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic dev_off_n,
    input  logic wsm_busy,
    output logic run,
    output logic kill,
    output logic abort_q
);
    localparam int HW = $clog2(RST_HOLD + 1);
    localparam int RW = $clog2(RST_REL + 1);
    localparam logic [HW-1:0] HOLD_MAX = HW'(RST_HOLD);
    localparam logic [RW-1:0] REL_MAX  = RW'(RST_REL);

    phase_e        ph_q;
    logic [HW-1:0] hold_q;
    logic [RW-1:0] rel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_RUN;
            hold_q  <= '0;
            rel_q   <= '0;
            abort_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_RUN: begin
                    if (!dev_off_n) begin
                        ph_q    <= PH_HOLD;
                        hold_q  <= HW'(1);
                        abort_q <= wsm_busy;
                    end
                end
                PH_HOLD: begin
                    if (hold_q != HOLD_MAX) hold_q <= hold_q + HW'(1);
                    if (dev_off_n && (hold_q == HOLD_MAX)) begin
                        ph_q  <= PH_REL;
                        rel_q <= RW'(1);
                    end
                end
                PH_REL: begin
                    if (!dev_off_n) begin
                        ph_q   <= PH_HOLD;
                        hold_q <= HW'(1);
                    end else if (rel_q == REL_MAX) begin
                        ph_q    <= PH_RUN;
                        abort_q <= 1'b0;
                    end else begin
                        rel_q <= rel_q + RW'(1);
                    end
                end
                default: ph_q <= PH_RUN;
            endcase
        end
    end

    assign run  = (ph_q == PH_RUN);
    assign kill = ~run | ~dev_off_n;
endmodule

// File: rtl/fci_cmd.sv
module fci_cmd
    import fci_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_evt,
    input  logic [AW-1:0]    evt_addr,
    input  logic [CMD_W-1:0] evt_data,
    input  logic             kill,
    input  logic             vdd_low,
    input  logic             pen_ok,
    input  logic             wsm_busy,
    output rd_mode_e         mode_q,
    output err_t             err_q,
    output logic             start,
    output op_e              start_kind,
    output logic [AW-1:0]    start_addr,
    output logic [CMD_W-1:0] start_data
);
    arm_e arm_q;
    logic accept;
    logic want_op;
    logic bad_seq;
    op_e  kind_c;

    assign accept = wr_evt & ~kill & ~vdd_low & ~wsm_busy;

    always_comb begin
        want_op = 1'b0;
        bad_seq = 1'b0;
        kind_c  = OP_ERASE;
        case (arm_q)
            ARM_ERASE: begin
                if (evt_data == CMD_GO) want_op = 1'b1;
                else                    bad_seq = 1'b1;
            end
            ARM_PROG: begin
                want_op = 1'b1;
                kind_c  = OP_PROG;
            end
            ARM_LOCK: begin
                if (evt_data == CMD_LSET) begin
                    want_op = 1'b1;
                    kind_c  = OP_LSET;
                end else if (evt_data == CMD_GO) begin
                    want_op = 1'b1;
                    kind_c  = OP_LCLR;
                end else begin
                    bad_seq = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign start      = accept & want_op & pen_ok;
    assign start_kind = kind_c;
    assign start_addr = evt_addr;
    assign start_data = evt_data;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            mode_q <= RD_ARRAY;
            arm_q  <= ARM_NONE;
            err_q  <= '0;
        end else if (vdd_low) begin
            mode_q <= RD_ARRAY;
            arm_q  <= ARM_NONE;
        end else if (accept) begin
            if (arm_q != ARM_NONE) begin
                arm_q  <= ARM_NONE;
                mode_q <= RD_STATUS;
                if (bad_seq) begin
                    err_q.seq <= 1'b1;
                end else if (!pen_ok) begin
                    err_q.pen <= 1'b1;
                    if (charges_erase_flag(kind_c)) err_q.ers <= 1'b1;
                    else                            err_q.prg <= 1'b1;
                end
            end else begin
                case (evt_data)
                    CMD_ARRAY:  mode_q <= RD_ARRAY;
                    CMD_STATUS: mode_q <= RD_STATUS;
                    CMD_CLR:    err_q  <= '0;
                    CMD_ERASE: begin
                        arm_q  <= ARM_ERASE;
                        mode_q <= RD_STATUS;
                    end
                    CMD_PROG: begin
                        arm_q  <= ARM_PROG;
                        mode_q <= RD_STATUS;
                    end
                    CMD_LOCK: begin
                        arm_q  <= ARM_LOCK;
                        mode_q <= RD_STATUS;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fci_wsm.sv
module fci_wsm
    import fci_pkg::*;
#(
    parameter int AW        = 16,
    parameter int ERASE_CYC = 20,
    parameter int PROG_CYC  = 6,
    parameter int LOCK_CYC  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             start,
    input  op_e              kind,
    input  logic [AW-1:0]    addr,
    input  logic [CMD_W-1:0] data,
    output logic             busy,
    output logic             go,
    output op_e              go_kind,
    output logic [AW-1:0]    go_addr,
    output logic [CMD_W-1:0] go_data
);
    localparam int MAX_EP = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int MAXC   = (MAX_EP > LOCK_CYC) ? MAX_EP : LOCK_CYC;
    localparam int CW     = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    function automatic logic [CW-1:0] last_tick(input op_e k);
        case (k)
            OP_ERASE: return CW'(ERASE_CYC - 1);
            OP_PROG:  return CW'(PROG_CYC - 1);
            default:  return CW'(LOCK_CYC - 1);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt_q   <= '0;
            go      <= 1'b0;
            go_kind <= OP_ERASE;
            go_addr <= '0;
            go_data <= '0;
        end else begin
            go <= start;
            if (start) begin
                busy    <= 1'b1;
                cnt_q   <= last_tick(kind);
                go_kind <= kind;
                go_addr <= addr;
                go_data <= data;
            end else if (abort) begin
                busy  <= 1'b0;
                cnt_q <= '0;
            end else if (busy) begin
                if (cnt_q == '0) busy  <= 1'b0;
                else             cnt_q <= cnt_q - CW'(1);
            end
        end
    end
endmodule

// File: rtl/fci_ctrl.sv
module fci_ctrl
    import fci_pkg::*;
#(
    parameter int AW        = 16,
    parameter int RST_HOLD  = 6,
    parameter int RST_REL   = 4,
    parameter int ERASE_CYC = 20,
    parameter int PROG_CYC  = 6,
    parameter int LOCK_CYC  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          pen_ok,
    input  logic          vdd_low,
    input  logic          dev_off_n,
    output logic          rd_stat,
    output logic [7:0]    stat,
    output logic          busy_n,
    output logic          op_go,
    output logic [1:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_data
);
    logic             wr_evt;
    logic [AW-1:0]    evt_addr;
    logic [CMD_W-1:0] evt_data;
    logic             run;
    logic             kill;
    logic             abort_q;
    logic             wsm_busy;
    rd_mode_e         mode_q;
    err_t             err_q;
    logic             start;
    op_e              start_kind;
    logic [AW-1:0]    start_addr;
    logic [CMD_W-1:0] start_data;
    op_e              go_kind;

    fci_busif #(.AW(AW)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .wr_n     (wr_n),
        .addr     (addr),
        .din      (din),
        .wr_evt   (wr_evt),
        .evt_addr (evt_addr),
        .evt_data (evt_data)
    );

    fci_rstseq #(.RST_HOLD(RST_HOLD), .RST_REL(RST_REL)) u_rseq (
        .clk       (clk),
        .rst       (rst),
        .dev_off_n (dev_off_n),
        .wsm_busy  (wsm_busy),
        .run       (run),
        .kill      (kill),
        .abort_q   (abort_q)
    );

    fci_cmd #(.AW(AW)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .wr_evt     (wr_evt),
        .evt_addr   (evt_addr),
        .evt_data   (evt_data),
        .kill       (kill),
        .vdd_low    (vdd_low),
        .pen_ok     (pen_ok),
        .wsm_busy   (wsm_busy),
        .mode_q     (mode_q),
        .err_q      (err_q),
        .start      (start),
        .start_kind (start_kind),
        .start_addr (start_addr),
        .start_data (start_data)
    );

    fci_wsm #(
        .AW(AW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .LOCK_CYC(LOCK_CYC)
    ) u_wsm (
        .clk     (clk),
        .rst     (rst),
        .abort   (kill),
        .start   (start),
        .kind    (start_kind),
        .addr    (start_addr),
        .data    (start_data),
        .busy    (wsm_busy),
        .go      (op_go),
        .go_kind (go_kind),
        .go_addr (op_addr),
        .go_data (op_data)
    );

    assign op_kind = go_kind;
    assign rd_stat = (mode_q == RD_STATUS);
    assign stat    = pack_status(~wsm_busy, err_q);
    assign busy_n  = ~(wsm_busy | abort_q);
endmodule

// File: rtl/fci_ctrl_chk.sv
module fci_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       wr_n,
    input logic [7:0] din,
    input logic       pen_ok,
    input logic       vdd_low,
    input logic       dev_off_n,
    input logic       run,
    input logic       rd_stat,
    input logic [7:0] stat,
    input logic       busy_n,
    input logic       op_go
);
    AST_GO_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        op_go |-> $past(sel && !wr_n)); // R2

    AST_GO_GATED: assert property (@(posedge clk) disable iff (rst)
        op_go |-> $past(dev_off_n && !vdd_low && pen_ok && busy_n && run)); // R7

    AST_LOCKOUT_ARRAY: assert property (@(posedge clk) disable iff (rst)
        vdd_low |=> !rd_stat); // R11

    AST_MODE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (run && dev_off_n && !vdd_low && !(sel && !wr_n)) |=> $stable(rd_stat)); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (($past(stat[5:2]) & ~stat[5:2]) != 4'd0)
            |-> $past(!dev_off_n || !run || (sel && !wr_n && din == 8'h50))); // R10

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !dev_off_n |=> (stat[5:2] == 4'd0)); // R12

    AST_ABORT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!dev_off_n && !busy_n) |=> !busy_n); // R13

    AST_READY_MIRROR: assert property (@(posedge clk) disable iff (rst)
        run |-> (stat[7] == busy_n)); // R8
endmodule

bind fci_ctrl fci_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .wr_n      (wr_n),
    .din       (din),
    .pen_ok    (pen_ok),
    .vdd_low   (vdd_low),
    .dev_off_n (dev_off_n),
    .run       (run),
    .rd_stat   (rd_stat),
    .stat      (stat),
    .busy_n    (busy_n),
    .op_go     (op_go)
);

// File: tb/fci_ctrl_tb.sv
`timescale 1ns/1ps
module fci_ctrl_tb;
    localparam int AW        = 16;
    localparam int RST_HOLD  = 6;
    localparam int RST_REL   = 4;
    localparam int ERASE_CYC = 20;
    localparam int PROG_CYC  = 6;
    localparam int LOCK_CYC  = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          pen_ok = 1'b1;
    logic          vdd_low = 1'b0;
    logic          dev_off_n = 1'b1;
    logic          rd_stat;
    logic [7:0]    stat;
    logic          busy_n;
    logic          op_go;
    logic [1:0]    op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0]    op_data;

    int checks = 0;
    int errors = 0;
    int go_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fci_ctrl #(
        .AW(AW), .RST_HOLD(RST_HOLD), .RST_REL(RST_REL),
        .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .LOCK_CYC(LOCK_CYC)
    ) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_n(wr_n), .addr(addr), .din(din),
        .pen_ok(pen_ok), .vdd_low(vdd_low), .dev_off_n(dev_off_n),
        .rd_stat(rd_stat), .stat(stat), .busy_n(busy_n), .op_go(op_go),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
    );

    always @(posedge clk) if (op_go) go_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [AW-1:0] a = '0);
        @(negedge clk); sel = 1'b1; wr_n = 1'b0; din = d; addr = a;
        @(negedge clk); sel = 1'b0; wr_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_state;
        chk("R1 mode after reset", rd_stat, 0);
        chk("R1 status after reset", stat, 8'h80);
        chk("R1 busy after reset", busy_n, 1);
        chk("R1 no go after reset", op_go, 0);
    endtask

    task automatic t_codes;
        wr(8'h70); chk("R3 status select", rd_stat, 1);
        wr(8'hFF); chk("R3 array select", rd_stat, 0);
        wr(8'hA5); chk("R3 unknown in array", rd_stat, 0);
        wr(8'h70); wr(8'hA5);
        chk("R3 unknown in status", rd_stat, 1);
        chk("R3 unknown leaves status", stat, 8'h80);
        wr(8'hFF);
    endtask

    task automatic t_gating;
        int g0;
        g0 = go_cnt;
        @(negedge clk); sel = 1'b0; wr_n = 1'b0; din = 8'h70;
        idle(2); wr_n = 1'b1;
        @(negedge clk);
        chk("R2 deselected write ignored", rd_stat, 0);
        sel = 1'b1; din = 8'h70; idle(2); sel = 1'b0;
        @(negedge clk);
        chk("R2 strobe high write ignored", rd_stat, 0);
        // held strobe: arm lock, change data while held
        sel = 1'b1; wr_n = 1'b0; din = 8'h60;
        @(negedge clk); din = 8'hD0;
        idle(2); sel = 1'b0; wr_n = 1'b1;
        idle(2);
        chk("R2 held strobe counts once", go_cnt, g0);
        chk("R4 arm selects status", rd_stat, 1);
        wr(8'h01, 16'h0123);
        chk("R4 lock set go", op_go, 1);
        chk("R4 lock set kind", op_kind, 2);
        chk("R4 lock set addr", op_addr, 16'h0123);
        idle(LOCK_CYC);
        chk("R8 lock done", busy_n, 1);
        chk("R2 one op from held strobe", go_cnt, g0 + 1);
    endtask

    task automatic t_erase;
        int g0;
        g0 = go_cnt;
        wr(8'hFF);
        wr(8'h20); wr(8'hD0, 16'h4000);
        chk("R4 erase go", op_go, 1);
        chk("R4 erase kind", op_kind, 0);
        chk("R4 erase addr", op_addr, 16'h4000);
        chk("R8 busy on confirm", busy_n, 0);
        chk("R8 ready bit low", stat[7], 0);
        wr(8'hFF);
        chk("R8 write ignored while busy", rd_stat, 1);
        wr(8'h20); wr(8'hD0);
        idle(ERASE_CYC - 7);
        chk("R8 erase still busy", busy_n, 0);
        @(negedge clk);
        chk("R8 erase ends", busy_n, 1);
        chk("R8 ready after erase", stat, 8'h80);
        chk("R9 mode kept after completion", rd_stat, 1);
        chk("R8 no op from busy writes", go_cnt, g0 + 1);
        @(negedge clk); sel = 1'b1; @(negedge clk); sel = 1'b0;
        pen_ok = 1'b0; @(negedge clk); pen_ok = 1'b1; @(negedge clk);
        chk("R9 select/pen toggles keep mode", rd_stat, 1);
    endtask

    task automatic t_program;
        wr(8'hFF);
        wr(8'h40); wr(8'h3C, 16'h0077);
        chk("R5 program go", op_go, 1);
        chk("R5 program kind", op_kind, 1);
        chk("R5 program data", op_data, 8'h3C);
        chk("R5 program addr", op_addr, 16'h0077);
        idle(PROG_CYC - 1);
        chk("R8 program still busy", busy_n, 0);
        @(negedge clk);
        chk("R8 program ends", busy_n, 1);
    endtask

    task automatic t_lock_clear;
        wr(8'h60); wr(8'hD0, 16'h0200);
        chk("R4 lock clear go", op_go, 1);
        chk("R4 lock clear kind", op_kind, 3);
        idle(LOCK_CYC);
        chk("R4 lock clear done", busy_n, 1);
    endtask

    task automatic t_seq_err;
        wr(8'hFF);
        wr(8'h20); wr(8'h33);
        chk("R6 bad erase confirm no go", op_go, 0);
        chk("R6 bad confirm selects status", rd_stat, 1);
        chk("R6 seq flag erase", stat, 8'h84);
        wr(8'h50);
        chk("R3 clear status", stat, 8'h80);
        wr(8'h60); wr(8'h55);
        chk("R6 seq flag lock", stat, 8'h84);
        wr(8'h50);
    endtask

    task automatic t_pen;
        int g0;
        g0 = go_cnt;
        pen_ok = 1'b0;
        wr(8'h20); wr(8'hD0);
        chk("R7 erase refused", op_go, 0);
        chk("R7 erase pen flags", stat, 8'hA8);
        wr(8'hFF); wr(8'h70);
        chk("R10 flags survive mode writes", stat, 8'hA8);
        wr(8'h40); wr(8'h11);
        chk("R7 program pen flags", stat, 8'hB8);
        pen_ok = 1'b1;
        idle(2);
        chk("R7 no ops with pen low", go_cnt, g0);
        chk("R10 flags survive pen rise", stat, 8'hB8);
        wr(8'h50);
        chk("R10 clear write drops flags", stat, 8'h80);
    endtask

    task automatic t_vdd;
        wr(8'h70);
        vdd_low = 1'b1;
        @(negedge clk);
        chk("R11 lockout forces array", rd_stat, 0);
        wr(8'h70);
        chk("R11 writes ignored in lockout", rd_stat, 0);
        wr(8'h20);
        vdd_low = 1'b0;
        wr(8'hD0);
        chk("R11 arm dropped no go", op_go, 0);
        chk("R11 arm dropped mode", rd_stat, 0);
    endtask

    task automatic t_rst_abort;
        int g0;
        wr(8'h20); wr(8'h33);
        chk("R12 flag set before reset", stat, 8'h84);
        wr(8'h20); wr(8'hD0);
        g0 = go_cnt;
        idle(3);
        dev_off_n = 1'b0;
        wr(8'h70);
        chk("R12 flags cleared in reset", stat[5:2], 0);
        chk("R13 busy held in reset", busy_n, 0);
        idle(6);
        dev_off_n = 1'b1;
        idle(RST_REL);
        chk("R13 busy held in release", busy_n, 0);
        @(negedge clk);
        chk("R13 busy free at end", busy_n, 1);
        chk("R12 write during reset ignored", rd_stat, 0);
        chk("R12 status after reset", stat, 8'h80);
        idle(ERASE_CYC + 5);
        chk("R13 op not resumed", busy_n, 1);
        chk("R13 no new op", go_cnt, g0 + 1);
    endtask

    task automatic t_short_pulse;
        wr(8'h20); wr(8'hD0);
        dev_off_n = 1'b0;
        idle(2);
        dev_off_n = 1'b1;
        idle(RST_HOLD + RST_REL - 2);
        chk("R12 short pulse still held", busy_n, 0);
        @(negedge clk);
        chk("R12 short pulse min hold end", busy_n, 1);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_codes();
        t_gating();
        t_erase();
        t_program();
        t_lock_clear();
        t_seq_err();
        t_pen();
        t_vdd();
        t_rst_abort();
        t_short_pulse();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule